// File: doc/BRIEF.md
# Pixel-Group Hit Store with Trigger-Latency Release

This block is the digital logic shared by a small group of pixels inside a pixel matrix. It watches the discriminator outputs of the group and measures each hit's time over threshold in clock cycles, with a mask of the pixels that fired. It stores the result in one of a few local cells. Each stored cell counts down a programmable latency. When the countdown ends, the cell is kept only if the trigger input is high in that exact clock cycle. Otherwise the cell is freed silently. Most hits are never triggered, so they never produce traffic outside the group.

Triggered cells are offered on a valid/ready output, lowest cell index first. A cell stays occupied until the downstream logic accepts it. Two saturating counters record hits lost because every cell was busy, and new pixels that joined a measurement already in progress. A synchronous clear input resets both counters.

Top module: `region_hit_store`

## Requirements
- R1: After reset, `outValid` is 0 and both `overflowCount` and `pileupCount` are 0.
- R2: The first rising clock edge that samples any `discIn` bit high stores the hit in a free cell, with its latency countdown loaded from `latency` (L). If `trigIn` is high at the (L+1)-th rising edge after that capture edge, the cell is presented with `outValid`=1, `outMask` holding every pixel bit seen during the hit and `outTot` holding its time over threshold.
- R3: A stored hit whose trigger is absent at its release edge, including a trigger one edge early or one edge late, is discarded and never appears on the output.
- R4: `outTot` equals the number of rising edges at which at least one `discIn` bit was high during the hit, saturating at 15. `outTotSat` is 1 only when the hit lasted more than 15 edges.
- R5: A `discIn` bit that rises while a measurement is running is merged into that measurement: it is OR-ed into the mask, it extends the ToT and it takes no new cell. Each sampled edge with such a rise adds one to `pileupCount`.
- R6: A hit that begins while all NUM_CELLS cells are occupied is lost and adds one to `overflowCount`. Cells freed by expiry are reusable.
- R7: Ready cells leave through `outValid`/`outReady`, lowest cell index first. A cell is held until accepted. A new hit takes the lowest-index free cell.
- R8: Both counters saturate at 255. A high `cntClear` at a rising edge sets both to 0.
- R9: A `latency` value of 0 behaves as a latency of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| discIn | input | 4 | Discriminator outputs of the grouped pixels |
| trigIn | input | 1 | Trigger, sampled once per clock |
| latency | input | 8 | Trigger latency in clock cycles |
| cntClear | input | 1 | Synchronous clear of both counters |
| outReady | input | 1 | Downstream accepts the presented hit |
| outValid | output | 1 | A triggered hit is presented |
| outTot | output | 4 | Time over threshold of the presented hit |
| outTotSat | output | 1 | ToT of the presented hit saturated |
| outMask | output | 4 | Pixel hit mask of the presented hit |
| overflowCount | output | 8 | Hits lost with all cells busy (saturating) |
| pileupCount | output | 8 | Pixel rises merged into a running measurement (saturating) |

## Verification
The bench places triggers exactly on the release edge and one edge to either side of it. An off-by-one latency counter would release the wrong hits or drop the right ones. It drives hits of 15 and 17 cycles to separate a ToT that wraps, or flags saturation too early, from a correct one. It frees cell 0 by expiry while cell 1 still waits, then makes a younger hit claim cell 0. A design that released cells in age order, or allocated cells round-robin, would present the hits in the wrong order. It also runs six hits into five cells, overlapping pixel rises, and 300 pile-up events. These catch a lost hit that is not counted, a merged pixel that takes its own cell, and a counter that wraps instead of saturating.

// File: rtl/region_store_pkg.sv
package region_store_pkg;

  localparam int PIX_N = 4;
  localparam int TOT_W = 4;

  typedef enum logic [1:0] {
    CELL_FREE  = 2'd0,
    CELL_WAIT  = 2'd1,
    CELL_READY = 2'd2
  } cellState_t;

  typedef struct packed {
    logic             alloc;
    logic             update;
    logic             totSat;
    logic [TOT_W-1:0] tot;
    logic [PIX_N-1:0] mask;
  } cellStrobe_t;

endpackage

// File: rtl/region_store_ctrl.sv
module region_store_ctrl
  import region_store_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_N-1:0] discIn,
  input  logic             cntClear,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  output cellStrobe_t      strb,
  output logic [IDX_W-1:0] cellIdx,
  output logic [CNT_W-1:0] overflowCount,
  output logic [CNT_W-1:0] pileupCount
);

  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             measuring;
  logic [PIX_N-1:0] prevDisc;
  logic [TOT_W-1:0] totReg;
  logic             satReg;
  logic [PIX_N-1:0] maskReg;
  logic             haveCell;
  logic [IDX_W-1:0] cellIdxReg;

  logic             anyHit, startHit, contHit, pileEvt;
  logic [TOT_W-1:0] totNext;
  logic             satNext;
  logic [PIX_N-1:0] maskNext;

  always_comb begin
    anyHit   = |discIn;
    startHit = anyHit && !measuring;
    contHit  = anyHit && measuring;
    pileEvt  = contHit && |(discIn & ~prevDisc);
    totNext  = (totReg == TOT_MAX) ? totReg : totReg + 1'b1;
    satNext  = satReg || (totReg == TOT_MAX);
    maskNext = maskReg | discIn;
  end

  always_comb begin
    strb = '0;
    if (startHit) begin
      strb.alloc  = freeAny;
      strb.tot    = TOT_W'(1);
      strb.totSat = 1'b0;
      strb.mask   = discIn;
    end else if (contHit) begin
      strb.update = haveCell;
      strb.tot    = totNext;
      strb.totSat = satNext;
      strb.mask   = maskNext;
    end
    cellIdx = startHit ? freeIdx : cellIdxReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measuring  <= 1'b0;
      prevDisc   <= '0;
      totReg     <= '0;
      satReg     <= 1'b0;
      maskReg    <= '0;
      haveCell   <= 1'b0;
      cellIdxReg <= '0;
    end else begin
      measuring <= anyHit;
      prevDisc  <= discIn;
      if (startHit) begin
        totReg     <= TOT_W'(1);
        satReg     <= 1'b0;
        maskReg    <= discIn;
        haveCell   <= freeAny;
        cellIdxReg <= freeIdx;
      end else if (contHit) begin
        totReg  <= totNext;
        satReg  <= satNext;
        maskReg <= maskNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowCount <= '0;
      pileupCount   <= '0;
    end else if (cntClear) begin
      overflowCount <= '0;
      pileupCount   <= '0;
    end else begin
      if (startHit && !freeAny && overflowCount != CNT_MAX)
        overflowCount <= overflowCount + 1'b1;
      if (pileEvt && pileupCount != CNT_MAX)
        pileupCount <= pileupCount + 1'b1;
    end
  end

endmodule

// File: rtl/region_store_cells.sv
module region_store_cells
  import region_store_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int LAT_W     = 8,
  localparam int IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellStrobe_t      strb,
  input  logic [IDX_W-1:0] cellIdx,
  input  logic             trigIn,
  input  logic [LAT_W-1:0] latency,
  input  logic             outReady,
  output logic             freeAny,
  output logic [IDX_W-1:0] freeIdx,
  output logic             outValid,
  output logic [TOT_W-1:0] outTot,
  output logic             outTotSat,
  output logic [PIX_N-1:0] outMask
);

  cellState_t       cellState [NUM_CELLS];
  logic [LAT_W-1:0] cellCnt   [NUM_CELLS];
  logic [TOT_W-1:0] cellTot   [NUM_CELLS];
  logic             cellSat   [NUM_CELLS];
  logic [PIX_N-1:0] cellMask  [NUM_CELLS];

  logic [LAT_W-1:0] latLoad;
  logic [IDX_W-1:0] rdyIdx;
  logic             popNow;

  always_comb begin
    latLoad = (latency == '0) ? LAT_W'(1) : latency;
    freeAny = 1'b0;
    freeIdx = '0;
    outValid = 1'b0;
    rdyIdx   = '0;
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      if (cellState[i] == CELL_FREE) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (cellState[i] == CELL_READY) begin
        outValid = 1'b1;
        rdyIdx   = IDX_W'(i);
      end
    end
    outTot    = cellTot[rdyIdx];
    outTotSat = cellSat[rdyIdx];
    outMask   = cellMask[rdyIdx];
    popNow    = outValid && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        cellState[i] <= CELL_FREE;
        cellCnt[i]   <= '0;
        cellTot[i]   <= '0;
        cellSat[i]   <= 1'b0;
        cellMask[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        unique case (cellState[i])
          CELL_FREE: begin
            if (strb.alloc && cellIdx == IDX_W'(i)) begin
              cellState[i] <= CELL_WAIT;
              cellCnt[i]   <= latLoad;
              cellTot[i]   <= strb.tot;
              cellSat[i]   <= strb.totSat;
              cellMask[i]  <= strb.mask;
            end
          end
          CELL_WAIT: begin
            if (cellCnt[i] == '0)
              cellState[i] <= trigIn ? CELL_READY : CELL_FREE;
            else
              cellCnt[i] <= cellCnt[i] - 1'b1;
            if (strb.update && cellIdx == IDX_W'(i)) begin
              cellTot[i]  <= strb.tot;
              cellSat[i]  <= strb.totSat;
              cellMask[i] <= strb.mask;
            end
          end
          CELL_READY: begin
            if (popNow && rdyIdx == IDX_W'(i))
              cellState[i] <= CELL_FREE;
          end
          default: cellState[i] <= CELL_FREE;
        endcase
      end
    end
  end

endmodule

// File: rtl/region_hit_store.sv
module region_hit_store
  import region_store_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_N-1:0] discIn,
  input  logic             trigIn,
  input  logic [LAT_W-1:0] latency,
  input  logic             cntClear,
  input  logic             outReady,
  output logic             outValid,
  output logic [TOT_W-1:0] outTot,
  output logic             outTotSat,
  output logic [PIX_N-1:0] outMask,
  output logic [CNT_W-1:0] overflowCount,
  output logic [CNT_W-1:0] pileupCount
);

  cellStrobe_t      strb;
  logic [IDX_W-1:0] cellIdx;
  logic             freeAny;
  logic [IDX_W-1:0] freeIdx;

  region_store_ctrl #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .discIn(discIn), .cntClear(cntClear),
    .freeAny(freeAny), .freeIdx(freeIdx), .strb(strb), .cellIdx(cellIdx),
    .overflowCount(overflowCount), .pileupCount(pileupCount)
  );

  region_store_cells #(.NUM_CELLS(NUM_CELLS), .LAT_W(LAT_W)) cellsInst (
    .clk(clk), .rstN(rstN), .strb(strb), .cellIdx(cellIdx), .trigIn(trigIn),
    .latency(latency), .outReady(outReady), .freeAny(freeAny), .freeIdx(freeIdx),
    .outValid(outValid), .outTot(outTot), .outTotSat(outTotSat), .outMask(outMask)
  );

endmodule

// File: rtl/region_store_chk.sv
module region_store_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntClear,
  input logic             outReady,
  input logic             outValid,
  input logic [3:0]       outTot,
  input logic             outTotSat,
  input logic [3:0]       outMask,
  input logic [CNT_W-1:0] overflowCount,
  input logic [CNT_W-1:0] pileupCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outMask != 4'd0);

  a_r4_sat_full: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTotSat) |-> outTot == 4'd15);

  a_r7_held: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  a_r6_ovf_step: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> (overflowCount == $past(overflowCount) ||
                   overflowCount == $past(overflowCount) + 1'b1));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> (overflowCount == '0 && pileupCount == '0));

  a_r8_pile_sat: assert property (@(posedge clk) disable iff (!rstN)
    (pileupCount == CNT_MAX && !cntClear) |=> pileupCount == CNT_MAX);

endmodule

bind region_hit_store region_store_chk #(.CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .cntClear(cntClear), .outReady(outReady),
  .outValid(outValid), .outTot(outTot), .outTotSat(outTotSat), .outMask(outMask),
  .overflowCount(overflowCount), .pileupCount(pileupCount)
);

// File: tb/region_hit_store_test.sv
module region_hit_store_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] discIn = '0;
  logic       trigIn = 1'b0;
  logic [7:0] latency = 8'd10;
  logic       cntClear = 1'b0;
  logic       outReady = 1'b0;
  logic       outValid, outTotSat;
  logic [3:0] outTot, outMask;
  logic [7:0] overflowCount, pileupCount;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 0;

  region_hit_store uut (
    .clk(clk), .rstN(rstN), .discIn(discIn), .trigIn(trigIn), .latency(latency),
    .cntClear(cntClear), .outReady(outReady), .outValid(outValid), .outTot(outTot),
    .outTotSat(outTotSat), .outMask(outMask), .overflowCount(overflowCount),
    .pileupCount(pileupCount)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic atCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic settle();
    trigIn = 0; discIn = 0; outReady = 0;
    repeat (270) @(negedge clk);
  endtask

  task automatic popOne();
    outReady = 1; @(negedge clk); outReady = 0;
  endtask

  task automatic clearCounters();
    cntClear = 1; @(negedge clk); cntClear = 0;
  endtask

  task automatic testReset();
    check("R1 outValid", outValid, 0);
    check("R1 overflowCount", overflowCount, 0);
    check("R1 pileupCount", pileupCount, 0);
  endtask

  task automatic testBasic();
    int a;
    settle(); latency = 8'd10; a = cyc + 2;
    atCyc(a); discIn = 4'b0101;
    atCyc(a + 3); discIn = 0;
    atCyc(a + 11); trigIn = 1;
    atCyc(a + 12); trigIn = 0;
    check("R2 valid on release", outValid, 1);
    check("R2 mask", outMask, 5);
    check("R4 tot", outTot, 3);
    check("R4 sat", outTotSat, 0);
    popOne();
    check("R7 freed after accept", outValid, 0);
  endtask

  task automatic testMiss();
    int a;
    settle(); latency = 8'd10; a = cyc + 2;
    atCyc(a); discIn = 4'b0001;
    atCyc(a + 1); discIn = 0;
    atCyc(a + 10); trigIn = 1;
    atCyc(a + 11); trigIn = 0;
    atCyc(a + 14);
    check("R3 early trigger discards", outValid, 0);
    a = cyc + 2;
    atCyc(a); discIn = 4'b0010;
    atCyc(a + 1); discIn = 0;
    atCyc(a + 12); trigIn = 1;
    atCyc(a + 13); trigIn = 0;
    atCyc(a + 15);
    check("R3 late trigger discards", outValid, 0);
  endtask

  task automatic testSat();
    int a;
    settle(); latency = 8'd30; a = cyc + 2;
    atCyc(a); discIn = 4'b1000;
    atCyc(a + 17); discIn = 0;
    atCyc(a + 31); trigIn = 1;
    atCyc(a + 32); trigIn = 0;
    check("R4 long hit tot", outTot, 15);
    check("R4 long hit sat", outTotSat, 1);
    popOne();
    a = cyc + 2;
    atCyc(a); discIn = 4'b1000;
    atCyc(a + 15); discIn = 0;
    atCyc(a + 31); trigIn = 1;
    atCyc(a + 32); trigIn = 0;
    check("R4 15-cycle tot", outTot, 15);
    check("R4 15-cycle sat", outTotSat, 0);
    popOne();
  endtask

  task automatic testPileup();
    int a;
    settle(); clearCounters(); latency = 8'd10; a = cyc + 2;
    atCyc(a); discIn = 4'b0001;
    atCyc(a + 2); discIn = 4'b0011;
    atCyc(a + 4); discIn = 0;
    atCyc(a + 11); trigIn = 1;
    atCyc(a + 12); trigIn = 0;
    check("R5 merged mask", outMask, 3);
    check("R5 merged tot", outTot, 4);
    check("R5 pileupCount", pileupCount, 1);
    popOne();
    check("R5 no second cell", outValid, 0);
  endtask

  task automatic testOverflow();
    int a;
    settle(); clearCounters(); latency = 8'd40; a = cyc + 2;
    for (int k = 0; k < 6; k++) begin
      atCyc(a + 2 * k); discIn = 4'b0001;
      atCyc(a + 2 * k + 1); discIn = 0;
    end
    atCyc(a + 12);
    check("R6 overflowCount", overflowCount, 1);
    atCyc(a + 60);
    check("R3 untriggered never shown", outValid, 0);
    latency = 8'd3; discIn = 4'b1000;
    atCyc(a + 61); discIn = 0;
    atCyc(a + 64); trigIn = 1;
    atCyc(a + 65); trigIn = 0;
    check("R6 freed cell reused", outMask, 8);
    popOne();
  endtask

  task automatic testOrder();
    int b;
    settle(); latency = 8'd8; b = cyc + 2;
    atCyc(b); discIn = 4'b0001;
    atCyc(b + 1); discIn = 0;
    atCyc(b + 2); discIn = 4'b0010;
    atCyc(b + 3); discIn = 0;
    atCyc(b + 11); trigIn = 1; discIn = 4'b1000;
    atCyc(b + 12); trigIn = 0; discIn = 0;
    check("R7 first ready shown", outMask, 2);
    atCyc(b + 20); trigIn = 1;
    atCyc(b + 21); trigIn = 0;
    check("R7 lower index first", outMask, 8);
    popOne();
    check("R7 next in order", outMask, 2);
    popOne();
    check("R7 empty after pops", outValid, 0);
  endtask

  task automatic testLatZero();
    int a;
    settle(); latency = 8'd0; a = cyc + 2;
    atCyc(a); discIn = 4'b0100;
    atCyc(a + 1); discIn = 0;
    atCyc(a + 2); trigIn = 1;
    atCyc(a + 3); trigIn = 0;
    check("R9 zero latency acts as 1", outValid, 1);
    popOne();
  endtask

  task automatic testCountSat();
    int a;
    settle(); clearCounters(); latency = 8'd255; a = cyc + 2;
    atCyc(a); discIn = 4'b0001;
    for (int k = 0; k < 300; k++) begin
      atCyc(a + 1 + 2 * k); discIn = 4'b0011;
      atCyc(a + 2 + 2 * k); discIn = 4'b0001;
    end
    discIn = 0;
    @(negedge clk);
    check("R8 pileup saturates", pileupCount, 255);
    clearCounters();
    check("R8 clear pileup", pileupCount, 0);
    check("R8 clear overflow", overflowCount, 0);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testBasic();
    testMiss();
    testSat();
    testPileup();
    testOverflow();
    testOrder();
    testLatZero();
    testCountSat();
    finishRun();
  end

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finishRun();
  end

endmodule